// File: doc/BRIEF.md
# Cross-Page Branch Target Translator

This block turns a branch that leaves the current page of emulated guest code into the real address of the translated bundle that implements the branch target. The guest effective address is the sum of a base register and an offset. The low 12 bits are the page offset, and the code guarantees that forming them needs no carry. The unit shifts that offset left by log2 of a power-of-two expansion factor, so that it points into a translated page that many times larger. In the same cycle it sends the upper bits, the guest virtual page number, to a small fully associative lookaside buffer. That buffer maps guest pages straight to translated-code frames. The scaled offset leaves the block at once, so that the instruction cache directory can be read in parallel. A hit counts only when the returned directory tag equals the frame from the buffer.

The result comes out one cycle after the request. It is either a redirect strobe with the target real address, a fetch-miss strobe, or a fault with a code. The target bundle's valid-entry marker is not known in time, so the redirect is issued optimistically. The marker is sampled in the following cycle, and a clear marker cancels the redirect with an invalid-entry fault. Branches that stay within the page, and branches through the link register, bypass both the lookaside buffer and the marker check. Software loads the buffer through a fill port. The fill port rewrites an existing entry for the same page in place, and otherwise replaces entries in round-robin order.

Top module: `xpage_branch_resolver`

## Requirements
- R1: While reset is high, and on the first cycle after it, the strobes redirect, fetch_miss, cancel and fault_valid are low and fault_code is 00. Reset also empties the lookaside buffer, so a later cross-page lookup of a page that was loaded before the reset reports code 01.
- R2: The effective address is base_reg + offset. The page number is its bits [31:12]. In the same cycle as the request, dir_index equals bits [11:0] of the effective address shifted left by log2(N), where N = 4 by default.
- R3: req_kind encodes branch kinds as 00 cross-page, 01 intra-page, 10 link register, 11 none. A cross-page request whose page hits a valid entry with the translation bit set, and whose dir_tag equals that entry's frame, raises redirect for one cycle on the cycle after the request. target_addr is then {frame, page offset, log2(N) zero bits}.
- R4: A cross-page request whose page matches no valid entry raises fault_valid with fault_code 01 (guest page fault) one cycle later. An entry loaded with its valid bit clear counts as absent even when its translation bit is set, so this fault outranks the missing-translation fault.
- R5: A cross-page request whose page hits a valid entry with the translation bit clear raises fault_valid with fault_code 10 (translation missing) one cycle later, and no redirect.
- R6: A cross-page request that hits with the translation bit set, but whose dir_tag differs from the frame, raises fetch_miss for one cycle and neither redirect nor a fault.
- R7: In the cycle after a cross-page redirect, entry_mark is sampled. If it is low, cancel and fault_valid rise together one cycle later with fault_code 11 (invalid entry). If it is high, nothing further is reported.
- R8: An intra-page request redirects one cycle later to {cur_frame, scaled page offset} and is never followed by a cancel, whatever entry_mark holds.
- R9: A link-register request redirects one cycle later with target_addr equal to base_reg, and is never followed by a cancel.
- R10: When an invalid-entry cancel is due in the same cycle as a new request, the cancel is reported, and the younger request is discarded without any strobe.
- R11: A fill whose page matches a valid entry rewrites that entry without moving the replacement pointer. Any other fill writes the entry at the pointer, which steps through the 16 entries in order and wraps.
- R12: A request of kind 11 produces no strobe. At most one of redirect, fetch_miss and fault_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Branch request present this cycle |
| req_kind | input | 2 | 00 cross-page, 01 intra-page, 10 link register, 11 none |
| base_reg | input | 32 | Base register value (real target for link-register branches) |
| offset | input | 32 | Offset added to base_reg |
| cur_frame | input | 18 | Frame of the bundle now executing, for intra-page branches |
| dir_index | output | 14 | Scaled page offset, driven to the cache directory in the request cycle |
| dir_tag | input | 18 | Frame tag returned by the cache directory for dir_index |
| entry_mark | input | 1 | Valid-entry marker of the redirected bundle, one cycle after redirect |
| fill_en | input | 1 | Write one lookaside buffer entry |
| fill_vpn | input | 20 | Guest virtual page number to load |
| fill_frame | input | 18 | Translated-code frame for that page |
| fill_valid | input | 1 | Page is mapped |
| fill_xlat | input | 1 | Translation of the page exists |
| redirect | output | 1 | Branch resolved; fetch from target_addr |
| target_addr | output | 32 | Real address of the target bundle |
| fetch_miss | output | 1 | Directory tag did not match the frame |
| cancel | output | 1 | Previous redirect withdrawn |
| fault_valid | output | 1 | Fault reported this cycle |
| fault_code | output | 2 | 01 guest page, 10 translation missing, 11 invalid entry |

## Verification
The bench builds the block with its default parameters: 32-bit guest addresses, 4 KB pages, expansion factor 4, 18-bit frames and a 16-entry buffer. With only 16 entries, a short run of fills wraps the replacement pointer. The bench can therefore see an eviction, an in-place rewrite and a further eviction that follows the pointer. An expansion factor above one makes the top page offset 0xFFC land at scaled offset 0x3FF0, which shows that the shift keeps all 14 index bits.

// File: rtl/xpb_pkg.sv
package xpb_pkg;
  typedef enum logic [1:0] {
    BR_CROSS = 2'd0,
    BR_INTRA = 2'd1,
    BR_LINK  = 2'd2,
    BR_NONE  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_GUEST_PAGE = 2'd1,
    FLT_NO_XLAT    = 2'd2,
    FLT_BAD_ENTRY  = 2'd3
  } flt_code_e;
endpackage

// File: rtl/xpb_addr.sv
module xpb_addr #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int XSHIFT  = 2,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int IDX_W  = PG_BITS + XSHIFT
) (
  input  logic [VA_W-1:0]  base,
  input  logic [VA_W-1:0]  off,
  output logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] scaled
);
  logic [VA_W-1:0] ea;

  assign ea  = base + off;
  assign vpn = ea[VA_W-1:PG_BITS];

  generate
    if (XSHIFT == 0) begin : g_noscale
      assign scaled = ea[PG_BITS-1:0];
    end else begin : g_scale
      assign scaled = {ea[PG_BITS-1:0], {XSHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/xpb_tlb.sv
module xpb_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 18,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic               lk_xlat,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_valid,
  input  logic               fill_xlat
);
  logic [ENTRIES-1:0] ent_v, ent_x, lk_match, fl_match;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [FRAME_W-1:0] ent_fr  [ENTRIES];
  logic [IW-1:0]      rr_ptr, fl_idx, wr_idx;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = ent_v[g] && (ent_vpn[g] == lk_vpn);
      assign fl_match[g] = ent_v[g] && (ent_vpn[g] == fill_vpn);
    end
  endgenerate

  always_comb begin
    lk_hit   = |lk_match;
    lk_xlat  = 1'b0;
    lk_frame = '0;
    fl_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_xlat  = lk_xlat | ent_x[i];
        lk_frame = lk_frame | ent_fr[i];
      end
      if (fl_match[i]) fl_idx = IW'(i);
    end
  end

  assign wr_idx = (|fl_match) ? fl_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v  <= '0;
      ent_x  <= '0;
      rr_ptr <= '0;
    end else if (fill_en) begin
      ent_v[wr_idx] <= fill_valid;
      ent_x[wr_idx] <= fill_xlat;
      if (!(|fl_match))
        rr_ptr <= (rr_ptr == IW'(ENTRIES - 1)) ? '0 : rr_ptr + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_vpn[wr_idx] <= fill_vpn;
      ent_fr[wr_idx]  <= fill_frame;
    end
  end
endmodule

// File: rtl/xpage_branch_resolver.sv
module xpage_branch_resolver #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int XSHIFT  = 2,
  parameter int FRAME_W = 18,
  parameter int TLB_N   = 16,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int IDX_W  = PG_BITS + XSHIFT,
  localparam int RA_W   = FRAME_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [VA_W-1:0]    base_reg,
  input  logic [VA_W-1:0]    offset,
  input  logic [FRAME_W-1:0] cur_frame,
  output logic [IDX_W-1:0]   dir_index,
  input  logic [FRAME_W-1:0] dir_tag,
  input  logic               entry_mark,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_valid,
  input  logic               fill_xlat,
  output logic               redirect,
  output logic [RA_W-1:0]    target_addr,
  output logic               fetch_miss,
  output logic               cancel,
  output logic               fault_valid,
  output logic [1:0]         fault_code
);
  import xpb_pkg::*;

  logic [VPN_W-1:0]   vpn;
  logic [IDX_W-1:0]   scaled;
  logic               tlb_hit, tlb_xlat;
  logic [FRAME_W-1:0] tlb_frame;
  logic               chk_pend;
  logic               squash;

  xpb_addr #(.VA_W(VA_W), .PG_BITS(PG_BITS), .XSHIFT(XSHIFT)) u_addr (
    .base(base_reg), .off(offset), .vpn(vpn), .scaled(scaled)
  );

  xpb_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_tlb (
    .clk(clk), .rst(rst), .lk_vpn(vpn), .lk_hit(tlb_hit), .lk_xlat(tlb_xlat),
    .lk_frame(tlb_frame), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_frame(fill_frame), .fill_valid(fill_valid), .fill_xlat(fill_xlat)
  );

  assign dir_index = scaled;
  assign squash    = chk_pend && !entry_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      target_addr <= '0;
      fetch_miss  <= 1'b0;
      cancel      <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      chk_pend    <= 1'b0;
    end else begin
      redirect    <= 1'b0;
      fetch_miss  <= 1'b0;
      cancel      <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      chk_pend    <= 1'b0;
      if (squash) begin
        cancel      <= 1'b1;
        fault_valid <= 1'b1;
        fault_code  <= FLT_BAD_ENTRY;
      end else if (req_valid) begin
        case (br_kind_e'(req_kind))
          BR_CROSS: begin
            if (!tlb_hit) begin
              fault_valid <= 1'b1;
              fault_code  <= FLT_GUEST_PAGE;
            end else if (!tlb_xlat) begin
              fault_valid <= 1'b1;
              fault_code  <= FLT_NO_XLAT;
            end else if (tlb_frame != dir_tag) begin
              fetch_miss <= 1'b1;
            end else begin
              redirect    <= 1'b1;
              target_addr <= {tlb_frame, scaled};
              chk_pend    <= 1'b1;
            end
          end
          BR_INTRA: begin
            redirect    <= 1'b1;
            target_addr <= {cur_frame, scaled};
          end
          BR_LINK: begin
            redirect    <= 1'b1;
            target_addr <= RA_W'(base_reg);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xpb_chk.sv
module xpb_chk #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 14,
  parameter int RA_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [VA_W-1:0]  base_reg,
  input logic [IDX_W-1:0] dir_index,
  input logic             redirect,
  input logic [RA_W-1:0]  target_addr,
  input logic             fetch_miss,
  input logic             cancel,
  input logic             fault_valid,
  input logic [1:0]       fault_code
);
  // R12
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect, fetch_miss, fault_valid}));

  // R7
  cancel_code_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |-> (fault_valid && fault_code == 2'b11));

  // R7
  cancel_follows_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |-> $past(redirect));

  // R3
  cross_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && $past(req_kind) == 2'b00) |-> target_addr[IDX_W-1:0] == $past(dir_index));

  // R9
  link_target_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && $past(req_kind) == 2'b10) |-> target_addr == RA_W'($past(base_reg)));

  // R4
  lookup_fault_src_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_code != 2'b11) |-> ($past(req_valid) && $past(req_kind) == 2'b00));

  // R12
  none_kind_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_kind) == 2'b11) |-> (!redirect && !fetch_miss));
endmodule

bind xpage_branch_resolver xpb_chk #(.VA_W(VA_W), .IDX_W(IDX_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .base_reg(base_reg), .dir_index(dir_index), .redirect(redirect),
  .target_addr(target_addr), .fetch_miss(fetch_miss), .cancel(cancel),
  .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/tb_xpage_branch_resolver.sv
module tb_xpage_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] CUR = 18'h00777;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] base;
    logic [31:0] off;
    logic [17:0] dtag;
    logic        mark;
    logic        rd;
    logic        fm;
    logic [1:0]  fc;
    logic        cn;
    logic [17:0] fr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h00030000, 32'h00000100, 18'h02000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 18'h02000},
    '{2'd0, 32'h00030ABC, 32'h00000000, 18'h02000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 18'h02000},
    '{2'd0, 32'h00041000, 32'h00000020, 18'h00000, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 18'h00000},
    '{2'd0, 32'h00055000, 32'h00000000, 18'h00000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 18'h00000},
    '{2'd0, 32'h00050000, 32'h00005000, 18'h00000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 18'h00000},
    '{2'd0, 32'h00066000, 32'h00000008, 18'h00000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 18'h00000},
    '{2'd0, 32'h00030000, 32'h00000010, 18'h01111, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 18'h00000},
    '{2'd0, 32'h00030000, 32'h00000040, 18'h02000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 18'h02000},
    '{2'd1, 32'h12345000, 32'h000007F0, 18'h00000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, CUR},
    '{2'd2, 32'h0ABC0040, 32'h00000000, 18'h00000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 18'h00000},
    '{2'd3, 32'h00030000, 32'h00000100, 18'h02000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 18'h00000},
    '{2'd0, 32'h00030000, 32'h00000FFC, 18'h02000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 18'h02000}
  };

  logic        clk = 1'b0;
  logic        rst, req_valid, entry_mark, fill_en, fill_valid, fill_xlat;
  logic [1:0]  req_kind;
  logic [31:0] base_reg, offset;
  logic [17:0] cur_frame, dir_tag, fill_frame;
  logic [19:0] fill_vpn;
  logic [13:0] dir_index;
  logic        redirect, fetch_miss, cancel, fault_valid;
  logic [31:0] target_addr;
  logic [1:0]  fault_code;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpage_branch_resolver dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .base_reg(base_reg), .offset(offset), .cur_frame(cur_frame),
    .dir_index(dir_index), .dir_tag(dir_tag), .entry_mark(entry_mark),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_valid(fill_valid), .fill_xlat(fill_xlat), .redirect(redirect),
    .target_addr(target_addr), .fetch_miss(fetch_miss), .cancel(cancel),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(input vec_t v);
    logic [31:0] ea;
    ea = v.base + v.off;
    if (v.kind == 2'd2) return v.base;
    return {v.fr, ea[11:0], 2'b00};
  endfunction

  function automatic string req_of(input int i);
    case (i)
      2: return "R5";
      3, 4, 5: return "R4";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic fill(input logic [19:0] vpn, input logic [17:0] fr,
                      input logic v, input logic x);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_frame = fr; fill_valid = v; fill_xlat = x;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    logic [31:0] ea;
    ea = v.base + v.off;
    @(negedge clk);
    req_valid = 1'b1; req_kind = v.kind; base_reg = v.base; offset = v.off;
    dir_tag = v.dtag;
    #1;
    chk("R2", "dir_index", 64'(dir_index), 64'({ea[11:0], 2'b00}));
    @(negedge clk);
    req_valid = 1'b0; entry_mark = v.mark;
    chk(req, "redirect", 64'(redirect), 64'(v.rd));
    chk(req, "fetch_miss", 64'(fetch_miss), 64'(v.fm));
    chk(req, "fault_valid", 64'(fault_valid), 64'(v.fc != 2'd0));
    chk(req, "fault_code", 64'(fault_code), 64'(v.fc));
    if (v.rd) chk(req, "target_addr", 64'(target_addr), 64'(exp_target(v)));
    @(negedge clk);
    entry_mark = 1'b1;
    chk(req, "cancel", 64'(cancel), 64'(v.cn));
    chk(req, "late fault_valid", 64'(fault_valid), 64'(v.cn));
    chk(req, "late fault_code", 64'(fault_code), v.cn ? 64'd3 : 64'd0);
    chk(req, "strobe one cycle", 64'(redirect), 64'd0);
  endtask

  function automatic vec_t lk(input logic [19:0] vpn, input logic [17:0] dtag,
                              input logic rd, input logic [1:0] fc);
    return '{2'd0, {vpn, 12'h000}, 32'h00000004, dtag, 1'b1, rd, 1'b0, fc, 1'b0, dtag};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; base_reg = '0; offset = '0;
    cur_frame = CUR; dir_tag = '0; entry_mark = 1'b1; fill_en = 1'b0;
    fill_vpn = '0; fill_frame = '0; fill_valid = 1'b0; fill_xlat = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset redirect", 64'(redirect), 64'd0);
    chk("R1", "reset fault_valid", 64'(fault_valid), 64'd0);
    chk("R1", "reset cancel/miss", 64'({cancel, fetch_miss, fault_code}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset strobes", 64'({redirect, fetch_miss, cancel, fault_valid}), 64'd0);

    fill(20'h00030, 18'h02000, 1'b1, 1'b1);
    fill(20'h00041, 18'h0ABCD, 1'b1, 1'b0);
    fill(20'h00066, 18'h03333, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], req_of(i));

    // R10: cancel of A wins over younger request B, which is discarded
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; base_reg = 32'h00030000; offset = 32'h40;
    dir_tag = 18'h02000;
    @(negedge clk);
    offset = 32'h80; entry_mark = 1'b0;
    chk("R10", "older redirect", 64'(redirect), 64'd1);
    @(negedge clk);
    req_valid = 1'b0; entry_mark = 1'b1;
    chk("R10", "cancel", 64'(cancel), 64'd1);
    chk("R10", "fault_code", 64'(fault_code), 64'd3);
    chk("R10", "younger dropped", 64'(redirect), 64'd0);
    @(negedge clk);
    chk("R10", "no late redirect", 64'({redirect, cancel}), 64'd0);

    // R7: back-to-back redirects both accepted when marker set
    @(negedge clk);
    req_valid = 1'b1; offset = 32'h40;
    @(negedge clk);
    offset = 32'h80; entry_mark = 1'b1;
    chk("R7", "first redirect", 64'(redirect), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "second redirect", 64'(redirect), 64'd1);
    chk("R7", "second target", 64'(target_addr), 64'h08000200);
    chk("R7", "no cancel", 64'(cancel), 64'd0);
    @(negedge clk);
    chk("R7", "no cancel after second", 64'(cancel), 64'd0);

    // R11: round-robin fill, slots 0..2 in use, pointer at 3
    for (int p = 0; p < 14; p++) fill(20'h00100 + 20'(p), 18'h01100 + 18'(p), 1'b1, 1'b1);
    run_vec(lk(20'h00030, 18'h02000, 1'b0, 2'd1), "R11");
    run_vec(lk(20'h0010D, 18'h0110D, 1'b1, 2'd0), "R11");
    fill(20'h00041, 18'h00123, 1'b1, 1'b1);
    run_vec(lk(20'h00041, 18'h00123, 1'b1, 2'd0), "R11");
    fill(20'h00200, 18'h00200, 1'b1, 1'b1);
    run_vec(lk(20'h00041, 18'h00123, 1'b0, 2'd1), "R11");
    run_vec(lk(20'h00100, 18'h01100, 1'b1, 2'd0), "R11");

    // R1: reset while a marker check is pending, then buffer is empty
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; base_reg = 32'h0010D000; offset = 32'h0;
    dir_tag = 18'h0110D;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1; entry_mark = 1'b0;
    chk("R1", "redirect before reset", 64'(redirect), 64'd1);
    @(negedge clk);
    rst = 1'b0; entry_mark = 1'b1;
    chk("R1", "cancel cleared by reset", 64'({cancel, fault_valid}), 64'd0);
    run_vec(lk(20'h0010D, 18'h0110D, 1'b0, 2'd1), "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule